// File: doc/BRIEF.md
# Serial Wire Debug Connection Sequencer

This block is the host side of a Serial Wire Debug link. A start pulse makes it bring an attached target's debug port from reset to an unlocked state. It produces the serial clock and drives the bidirectional data line through a separate output value and output enable. It reads the line back on a dedicated input. The whole bring-up is a fixed script. A mode-switch pattern and a line connection pattern go out first. Then come five transfers: an identification read, a debug power-up write, an access-port bank select write, and an access-port ID read. The ID read is collected through the debug port's read buffer. A short idle tail ends the script.

The script runs over a bit-level packet engine. Each packet has an 8-bit request, a turnaround, a 3-bit acknowledge, 32 data bits and an even parity bit. The engine also sends raw bit strings. Any acknowledge other than OK ends the run with an error. So does a read whose parity does not match. The error code names the step that failed. After a clean run the identification word and the access-port ID word stay on the outputs.

Top module: `swd_link_init`

## Requirements
- R1: While reset is high, swclk, swdio_oe, busy, done and error are all low.
- R2: swclk is low for HALF_CLKS clock cycles and then high for HALF_CLKS cycles. swdio_o and swdio_oe change only when swclk falls. Every serial field goes out least significant bit first.
- R3: After start, the first 16 bits driven by the host are 16'hE79E, sent LSB first.
- R4: Next the host drives 56 consecutive ones and then 8 zeros.
- R5: A request byte, LSB first, holds start=1 (bit 0), AP-not-DP (bit 1), read-not-write (bit 2), A[2] (bit 3), A[3] (bit 4), even parity of bits 1..4 (bit 5), stop=0 (bit 6) and park=1 (bit 7). The first transfer reads DP address 0 (request 8'hA5), and its data appears on idcode.
- R6: The second transfer writes 32'h5000_0000 (bits 30 and 28) to DP address 4 (request 8'hA9). Its data parity bit is the even parity of the 32 data bits.
- R7: The third transfer writes 32'h0000_00F0 to DP address 8 (request 8'hB1).
- R8: The fourth transfer reads AP address 0xFC (request 8'h9F), and its returned data is discarded. The fifth transfer reads DP address 0xC (request 8'hBD), and its data appears on ap_id.
- R9: After the fifth transfer the host drives 8 zeros. Then done goes high with busy low, and done stays high until the next start.
- R10: An acknowledge other than 3'b001 (bit 0 first on the line) stops the script. error is set and done is not. err_step then holds 3, 4, 5, 6 or 7 for transfers one to five.
- R11: A read whose parity bit does not match its data stops the script with error and the same err_step coding.
- R12: A start while idle sets busy and runs the full script again, even after a previous error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the connection script (taken only while idle) |
| swclk | output | 1 | Serial debug clock |
| swdio_o | output | 1 | Data line value from the host |
| swdio_oe | output | 1 | Host drives the data line when high |
| swdio_i | input | 1 | Data line as seen at the pin |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished successfully |
| error | output | 1 | Script stopped on a failed step |
| err_step | output | 3 | Step code of the failure (3 to 7) |
| idcode | output | 32 | Identification word read from DP address 0 |
| ap_id | output | 32 | Access-port ID word collected through the read buffer |

## Verification
busy is high one clock after the edge that captures start. Each serial bit lasts 2*HALF_CLKS clocks. With the default setting, a clean run is 318 bit periods, about 1272 clocks. done or error rises one clock after the rising swclk edge of the last bit of its step. The bench samples every port on the falling system clock. It polls for the result flags with a bound and does not count an exact cycle. A target model samples the host's bits on each rising swclk and drives its replies after the falling one. Through it the bench checks the bit order, the request bytes, the written words and the parity on the line.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int RAW_W = 64;
  localparam int LEN_W = $clog2(RAW_W + 1);
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] PWR_UP_VAL = 32'h5000_0000;
  localparam logic [WORD_W-1:0] BANK_SEL_VAL = 32'h0000_00F0;

  typedef enum logic [1:0] {OP_RAW, OP_READ, OP_WRITE} op_e;

  typedef struct packed {
    op_e              kind;
    logic             ap;
    logic [1:0]       addr;   // A[3:2]
    logic [LEN_W-1:0] nbits;
    logic [RAW_W-1:0] raw;
    logic [WORD_W-1:0] wdata;
  } swd_cmd_t;

  // request byte, bit 0 goes out first
  function automatic logic [7:0] req_byte(input logic ap, input logic rnw, input logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
  endfunction
endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  output logic swclk,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int PER = 2 * HALF_CLKS;
  localparam int CW = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] cnt;

  assign rise_tick = (cnt == CW'(HALF_CLKS - 1));
  assign fall_tick = (cnt == CW'(PER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick) swclk <= 1'b1;
      else if (fall_tick) swclk <= 1'b0;
    end
  end
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_tick,
  input  logic              rise_tick,
  input  logic              cmd_valid,
  input  swd_cmd_t          cmd_in,
  input  logic              swdio_i,
  output logic              swdio_o,
  output logic              swdio_oe,
  output logic              op_done,
  output logic              op_fault,
  output logic [WORD_W-1:0] op_rdata
);
  typedef enum logic [3:0] {
    PH_IDLE, PH_RAW, PH_REQ, PH_TRN_A, PH_ACK, PH_RDAT, PH_RPAR,
    PH_TRN_B, PH_WTRN, PH_WDAT, PH_WPAR
  } ph_e;

  ph_e               ph;
  swd_cmd_t          cq;
  logic              pend;
  op_e               kind;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  cnt;
  logic [RAW_W-1:0]  sh;
  logic [WORD_W-1:0] wd;
  logic              wpar;
  logic [1:0]        ack_lo;
  logic              last_bit;
  logic              go;
  swd_cmd_t          nc;

  assign go = pend | cmd_valid;
  assign nc = cmd_valid ? cmd_in : cq;
  assign last_bit = (ph == PH_RAW && cnt == len - 1'b1) || ph == PH_TRN_B || ph == PH_WPAR;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cq <= '0; pend <= 1'b0; kind <= OP_RAW; len <= '0;
      cnt <= '0; sh <= '0; wd <= '0; wpar <= 1'b0; ack_lo <= '0;
      swdio_o <= 1'b0; swdio_oe <= 1'b0; op_done <= 1'b0; op_fault <= 1'b0;
      op_rdata <= '0;
    end else begin
      op_done <= 1'b0;
      if (cmd_valid) begin
        cq   <= cmd_in;
        pend <= 1'b1;
      end
      // target-driven bits are taken on the rising clock
      if (rise_tick) begin
        case (ph)
          PH_ACK: begin
            if (cnt == LEN_W'(2)) op_fault <= ({swdio_i, ack_lo} != 3'b001);
            else ack_lo[cnt[0]] <= swdio_i;
          end
          PH_RDAT: op_rdata <= {swdio_i, op_rdata[WORD_W-1:1]};
          PH_RPAR: if (swdio_i != ^op_rdata) op_fault <= 1'b1;
          default: ;
        endcase
        if (last_bit) op_done <= 1'b1;
      end
      // host bits change on the falling clock
      if (fall_tick) begin
        if (ph == PH_IDLE || last_bit) begin
          if (go) begin
            pend <= 1'b0; kind <= nc.kind; len <= nc.nbits; cnt <= '0;
            wd <= nc.wdata; wpar <= ^nc.wdata; op_fault <= 1'b0; swdio_oe <= 1'b1;
            if (nc.kind == OP_RAW) begin
              ph <= PH_RAW; sh <= nc.raw; swdio_o <= nc.raw[0];
            end else begin
              ph <= PH_REQ; sh <= RAW_W'(req_byte(nc.ap, nc.kind == OP_READ, nc.addr));
              swdio_o <= 1'b1;
            end
          end else begin
            ph <= PH_IDLE; swdio_oe <= 1'b0; swdio_o <= 1'b0;
          end
        end else begin
          case (ph)
            PH_RAW: begin
              cnt <= cnt + 1'b1; sh <= sh >> 1; swdio_o <= sh[1];
            end
            PH_REQ: begin
              if (cnt == LEN_W'(7)) begin
                ph <= PH_TRN_A; swdio_oe <= 1'b0; cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1; sh <= sh >> 1; swdio_o <= sh[1];
              end
            end
            PH_TRN_A: begin ph <= PH_ACK; cnt <= '0; end
            PH_ACK: begin
              if (cnt != LEN_W'(2)) cnt <= cnt + 1'b1;
              else if (op_fault) ph <= PH_TRN_B;
              else if (kind == OP_READ) begin ph <= PH_RDAT; cnt <= '0; end
              else ph <= PH_WTRN;
            end
            PH_RDAT: begin
              if (cnt == LEN_W'(WORD_W - 1)) ph <= PH_RPAR;
              else cnt <= cnt + 1'b1;
            end
            PH_RPAR: ph <= PH_TRN_B;
            PH_WTRN: begin
              ph <= PH_WDAT; cnt <= '0; swdio_oe <= 1'b1; swdio_o <= wd[0];
            end
            PH_WDAT: begin
              if (cnt == LEN_W'(WORD_W - 1)) begin
                ph <= PH_WPAR; swdio_o <= wpar;
              end else begin
                cnt <= cnt + 1'b1; wd <= wd >> 1; swdio_o <= wd[1];
              end
            end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/swd_init_seq.sv
module swd_init_seq
  import swd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_done,
  input  logic              op_fault,
  input  logic [WORD_W-1:0] op_rdata,
  output logic              cmd_valid,
  output swd_cmd_t          cmd,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [2:0]        err_step,
  output logic [WORD_W-1:0] idcode,
  output logic [WORD_W-1:0] ap_id
);
  localparam logic [2:0] ST_IDC  = 3'd2;
  localparam logic [2:0] ST_BUF  = 3'd6;
  localparam logic [2:0] ST_LAST = 3'd7;

  logic [2:0] idx;

  always_comb begin
    cmd = '0;
    case (idx)
      3'd0: begin cmd.kind = OP_RAW; cmd.nbits = LEN_W'(16); cmd.raw = RAW_W'(16'hE79E); end
      3'd1: begin cmd.kind = OP_RAW; cmd.nbits = LEN_W'(64); cmd.raw = 64'h00FF_FFFF_FFFF_FFFF; end
      3'd2: begin cmd.kind = OP_READ; cmd.addr = 2'b00; end
      3'd3: begin cmd.kind = OP_WRITE; cmd.addr = 2'b01; cmd.wdata = PWR_UP_VAL; end
      3'd4: begin cmd.kind = OP_WRITE; cmd.addr = 2'b10; cmd.wdata = BANK_SEL_VAL; end
      3'd5: begin cmd.kind = OP_READ; cmd.ap = 1'b1; cmd.addr = 2'b11; end
      3'd6: begin cmd.kind = OP_READ; cmd.addr = 2'b11; end
      default: begin cmd.kind = OP_RAW; cmd.nbits = LEN_W'(8); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0; busy <= 1'b0; done <= 1'b0; error <= 1'b0; err_step <= '0;
      idcode <= '0; ap_id <= '0; cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; done <= 1'b0; error <= 1'b0; err_step <= '0;
        idx <= '0; cmd_valid <= 1'b1;
      end else if (busy && op_done) begin
        if (op_fault) begin
          busy <= 1'b0; error <= 1'b1; err_step <= idx + 3'd1;
        end else begin
          if (idx == ST_IDC) idcode <= op_rdata;
          if (idx == ST_BUF) ap_id <= op_rdata;
          if (idx == ST_LAST) begin
            busy <= 1'b0; done <= 1'b1;
          end else begin
            idx <= idx + 3'd1; cmd_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/swd_link_init.sv
module swd_link_init
  import swd_pkg::*;
#(
  parameter int HALF_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        swclk,
  output logic        swdio_o,
  output logic        swdio_oe,
  input  logic        swdio_i,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [2:0]  err_step,
  output logic [31:0] idcode,
  output logic [31:0] ap_id
);
  logic              fall_tick, rise_tick;
  logic              cmd_valid, op_done, op_fault;
  swd_cmd_t          cmd;
  logic [WORD_W-1:0] op_rdata;

  swd_clkgen #(.HALF_CLKS(HALF_CLKS)) u_clk (
    .clk(clk), .rst(rst), .swclk(swclk), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  swd_xfer_engine u_eng (
    .clk(clk), .rst(rst), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .cmd_valid(cmd_valid), .cmd_in(cmd), .swdio_i(swdio_i),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe),
    .op_done(op_done), .op_fault(op_fault), .op_rdata(op_rdata)
  );

  swd_init_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .op_done(op_done), .op_fault(op_fault), .op_rdata(op_rdata),
    .cmd_valid(cmd_valid), .cmd(cmd),
    .busy(busy), .done(done), .error(error), .err_step(err_step),
    .idcode(idcode), .ap_id(ap_id)
  );
endmodule

// File: rtl/swd_link_init_chk.sv
module swd_link_init_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [2:0] err_step
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !done && !error && !swdio_oe && !swclk)); // R1

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    swclk |-> ($stable(swdio_o) && $stable(swdio_oe))); // R2

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !error)); // R9

  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    error |-> (!busy && err_step >= 3'd3 && err_step <= 3'd7)); // R10
endmodule

bind swd_link_init swd_link_init_chk u_chk (.*);

// File: tb/swd_link_init_test.sv
module swd_link_init_test;
  localparam int HALF = 2;
  localparam logic [31:0] IDC = 32'h0BC1_1477;
  localparam logic [31:0] APV = 32'h4477_0021;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  always #4 clk = ~clk;

  wire swclk, swdio_o, swdio_oe, busy, done, error;
  wire [2:0] err_step;
  wire [31:0] idcode, ap_id;
  wire swdio_i;

  swd_link_init #(.HALF_CLKS(HALF)) uut (
    .clk(clk), .rst(rst), .start(start), .swclk(swclk), .swdio_o(swdio_o),
    .swdio_oe(swdio_oe), .swdio_i(swdio_i), .busy(busy), .done(done),
    .error(error), .err_step(err_step), .idcode(idcode), .ap_id(ap_id)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  logic t_drv = 1'b0, t_val = 1'b0, n_drv = 1'b0, n_val = 1'b0;
  int ones = 0, pos = 0, xfer = 0, hn = 0, wait_at = 0, perr_at = 0;
  int wpar_bad = 0, req_bad = 0;
  bit synced = 0, armed = 0, inpkt = 0, is_ap = 0, is_rd = 0, flt = 0;
  logic [7:0] req = '0;
  logic [1:0] adr = '0;
  logic [2:0] ackv = '0;
  logic [31:0] wd = '0, rdv = '0, apbuf = '0, ctrl_w = '0, sel_w = '0;
  logic [7:0] reqlog [1:8];
  bit hlog [0:511];

  assign swdio_i = t_drv ? t_val : (swdio_oe ? swdio_o : 1'b1);

  always @(negedge swclk) begin
    t_drv <= n_drv;
    t_val <= n_val;
  end

  always @(posedge swclk) begin
    logic b;
    b = swdio_i;
    n_drv = 1'b0; n_val = 1'b0;
    if (swdio_oe) begin
      if (hn < 512) hlog[hn] = b;
      hn++;
      ones = b ? ones + 1 : 0;
    end
    if (swdio_oe && ones >= 50) begin
      synced = 1; inpkt = 0; armed = 0;
    end else if (synced && !inpkt) begin
      if (swdio_oe && !b) armed = 1;
      else if (swdio_oe && b && armed) begin inpkt = 1; pos = 1; req = 8'h01; end
    end else if (inpkt) begin
      if (pos <= 7) begin
        req[pos] = b;
        if (pos == 7) begin
          xfer++;
          if (xfer <= 8) reqlog[xfer] = req;
          is_ap = req[1]; is_rd = req[2]; adr = {req[4], req[3]};
          if (req[5] != (req[1] ^ req[2] ^ req[3] ^ req[4]) || req[6] || !req[7]) req_bad++;
          flt = (xfer == wait_at);
          ackv = flt ? 3'b010 : 3'b001;
          if (is_rd) begin
            if (is_ap) begin
              rdv = apbuf;
              apbuf = (adr == 2'b11 && sel_w == 32'hF0) ? APV : 32'hDEAD_0000;
            end else rdv = (adr == 2'b00) ? IDC : (adr == 2'b11) ? apbuf : 32'h0;
          end
        end
      end else if (pos <= 10) begin
        n_drv = 1'b1; n_val = ackv[pos-8];
      end else if (pos == 11) begin
        if (flt) inpkt = 0;
        else if (is_rd) begin n_drv = 1'b1; n_val = rdv[0]; end
      end else if (is_rd) begin
        if (pos <= 42) begin n_drv = 1'b1; n_val = rdv[pos-11]; end
        else if (pos == 43) begin n_drv = 1'b1; n_val = (^rdv) ^ (xfer == perr_at); end
        else if (pos == 45) begin inpkt = 0; armed = 1; end
      end else begin
        if (pos >= 13 && pos <= 44) wd[pos-13] = b;
        else if (pos == 45) begin
          if (b != ^wd) wpar_bad++;
          if (!is_ap && adr == 2'b01) ctrl_w = wd;
          if (!is_ap && adr == 2'b10) sel_w = wd;
          inpkt = 0; armed = 1;
        end
      end
      pos++;
    end
  end

  // ---------------- clock width monitor ----------------
  int run = 0, clkbad = 0;
  bit seen = 0;
  logic prev_clk = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (swclk == prev_clk) run++;
      else begin
        if (seen && run != HALF) clkbad++;
        seen = 1; run = 1;
      end
      prev_clk = swclk;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic reset_model(input int w_at, input int p_at);
    synced = 0; armed = 0; inpkt = 0; ones = 0; xfer = 0; hn = 0;
    apbuf = '0; ctrl_w = '0; sel_w = '0; wpar_bad = 0; req_bad = 0;
    wait_at = w_at; perr_at = p_at;
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R12 busy after start", busy, 1);
  endtask

  task automatic wait_result();
    int n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(swclk === 1'b0 && swdio_oe === 1'b0, "R1 line quiet in reset", {swclk, swdio_oe}, 0);
    chk(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 flags low in reset",
        {busy, done, error}, 0);
    @(negedge clk) rst = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_full(input string tag);
    bit ok;
    reset_model(0, 0);
    kick();
    wait_result();
    chk(done === 1'b1 && error === 1'b0 && busy === 1'b0, {tag, " R9 done flags"},
        {busy, done, error}, 3'b010);
    ok = 1;
    for (int i = 0; i < 16; i++) if (hlog[i] != ((16'hE79E >> i) & 1)) ok = 0;
    chk(ok, {tag, " R3 switch pattern"}, 0, 16'hE79E);
    ok = 1;
    for (int i = 16; i < 72; i++) if (!hlog[i]) ok = 0;
    for (int i = 72; i < 80; i++) if (hlog[i]) ok = 0;
    chk(ok, {tag, " R4 ones then idle"}, 0, 1);
    chk(reqlog[1] == 8'hA5 && idcode == IDC, {tag, " R5 id read"}, idcode, IDC);
    chk(req_bad == 0, {tag, " R5 request framing"}, req_bad, 0);
    chk(reqlog[2] == 8'hA9 && ctrl_w == 32'h5000_0000, {tag, " R6 power write"}, ctrl_w, 32'h5000_0000);
    chk(wpar_bad == 0, {tag, " R6 write parity"}, wpar_bad, 0);
    chk(reqlog[3] == 8'hB1 && sel_w == 32'hF0, {tag, " R7 select write"}, sel_w, 32'hF0);
    chk(reqlog[4] == 8'h9F && reqlog[5] == 8'hBD && xfer == 5, {tag, " R8 ap requests"},
        {reqlog[4], reqlog[5]}, 16'h9FBD);
    chk(ap_id == APV, {tag, " R8 ap id"}, ap_id, APV);
    ok = (hn == 194) && hlog[hn-9];
    for (int i = hn - 8; i < hn; i++) if (hlog[i]) ok = 0;
    chk(ok, {tag, " R9 idle tail"}, hn, 194);
    chk(clkbad == 0, {tag, " R2 clock phases"}, clkbad, 0);
    repeat (40) @(negedge clk);
    chk(done === 1'b1, {tag, " R9 done held"}, done, 1);
  endtask

  task automatic t_fault(input int at, input logic [2:0] code, input bit par, input string req_tag);
    if (par) reset_model(0, at); else reset_model(at, 0);
    kick();
    wait_result();
    chk(error === 1'b1 && done === 1'b0 && busy === 1'b0, {req_tag, " error flags"},
        {busy, done, error}, 3'b001);
    chk(err_step == code, {req_tag, " step code"}, err_step, code);
    chk(xfer == at, {req_tag, " script stopped"}, xfer, at);
  endtask

  initial begin
    t_reset();
    t_full("run1");
    t_fault(2, 3'd4, 0, "R10 wait on power write");
    t_fault(5, 3'd7, 0, "R10 wait on buffer read");
    t_fault(1, 3'd3, 1, "R11 parity on id read");
    t_fault(4, 3'd6, 1, "R11 parity on ap read");
    t_full("R12 rerun");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule